// File: doc/BRIEF.md
# Rank Activate Window Limiter

This block tracks row activations for one DRAM rank and publishes a single earliest cycle at which the next activate may go to any bank of that rank. A memory controller's command scheduler reports each activate it issues, together with that activate's cycle stamp. The block folds in two rank-wide rules. The first is a minimum spacing between any two activates (`RRD` cycles). The second allows no more than `X` activates inside any rolling window of `XAW` cycles.

A shift history holds the stamps of the most recent activates, newest first. The runtime input `act_limit` selects how deep that history counts, from 0 up to the synthesis-time maximum `MAX_X`. A depth of 0 turns the window rule off. Each rule can only push the published cycle later. An activate that breaks the window rule sets a violation flag, and the flag stays set until reset. The block also keeps a count of open banks: an activate raises it and a precharge lowers it.

Top module: `rank_act_limiter`

## Requirements
- R1: While reset is asserted and after it is released, `earliest_act` is 0, `violation` is 0 and `active_banks` is 0.
- R2: One cycle after an activate with stamp A, `earliest_act` is at least A+RRD and is never below its previous value. Without an activate, it holds.
- R3: The history keeps the newest `act_limit` stamps in order. Each activate shifts it and drops the oldest. Call the oldest entry after the shift O. If O is non-zero and A−O is less than XAW, `earliest_act` becomes the larger of its value and O+XAW.
- R4: An activate is a violation in this case: before the shift, the oldest of the `act_limit` stored stamps is non-zero and lies fewer than XAW cycles before A. `violation` rises combinationally in the cycle of that activate and stays at 1 until reset.
- R5: With `act_limit` = 0, the window rule and the violation check are both off, and only the RRD spacing applies.
- R6: A stored stamp of 0 marks an empty entry. It neither constrains `earliest_act` nor raises `violation`.
- R7: A value of `act_limit` above MAX_X (8 by default) behaves as MAX_X.
- R8: `active_banks` rises by one on `act_valid` and falls by one on `pre_valid`. It is unchanged when both are high, and it saturates at 0 and at BANKS (8 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | An activate is issued to this rank this cycle |
| act_stamp | input | STAMP_W | Cycle stamp of that activate (0 reserved as empty) |
| act_limit | input | $clog2(MAX_X+1) | Window activate limit X; 0 disables the window |
| pre_valid | input | 1 | A bank of this rank is precharged this cycle |
| earliest_act | output | STAMP_W | Earliest stamp for the next activate to any bank |
| violation | output | 1 | Sticky window-rule violation flag |
| active_banks | output | $clog2(BANKS+1) | Number of banks with an open row |

## Verification
A history entry that is wrong shows up as a window limit that is too early or too late. It appears on `earliest_act` one cycle after the activate that makes the bad entry the oldest one. If the entry is wrong before the shift, `violation` rises or stays low wrongly in the very cycle of the next activate. A wrong depth select, including the clamp above MAX_X, moves the window limit to a neighbouring stamp. A counter fault shows on `active_banks` one cycle after the event. Dense bursts are therefore mixed with sparse ones, and every cycle is compared.

// File: rtl/rank_act_pkg.sv
package rank_act_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_step_e;

endpackage

// File: rtl/act_history.sv
module act_history #(
  parameter int DEPTH = 8,
  parameter int SW    = 16,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] stamp,
  input  logic [LW-1:0] depth_sel,
  output logic [SW-1:0] oldest_before,
  output logic [SW-1:0] oldest_after
);

  logic [SW-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [SW-1:0] slot_d;
    if (i == 0) begin : g_head
      assign slot_d = stamp;
    end else begin : g_body
      assign slot_d = slot_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (push) begin
        slot_q[i] <= slot_d;
      end
    end
  end

  always_comb begin
    oldest_before = '0;
    oldest_after  = '0;
    if (depth_sel == LW'(1)) begin
      oldest_after = stamp;
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (depth_sel == LW'(k + 1)) begin
        oldest_before = slot_q[k];
      end
      if (k > 0 && depth_sel == LW'(k + 1)) begin
        oldest_after = slot_q[k-1];
      end
    end
  end

endmodule

// File: rtl/act_window_calc.sv
module act_window_calc #(
  parameter int SW  = 16,
  parameter int RRD = 4,
  parameter int XAW = 20
) (
  input  logic          act,
  input  logic [SW-1:0] stamp,
  input  logic          window_on,
  input  logic [SW-1:0] oldest_before,
  input  logic [SW-1:0] oldest_after,
  input  logic [SW-1:0] cur_earliest,
  output logic [SW-1:0] nxt_earliest,
  output logic          breach
);

  logic [SW-1:0] spacing_at;
  logic [SW-1:0] window_at;
  logic          window_hit;

  always_comb begin
    spacing_at = stamp + SW'(RRD);
    window_at  = oldest_after + SW'(XAW);
    window_hit = window_on && (oldest_after != '0) &&
                 ((stamp - oldest_after) < SW'(XAW));
    breach     = act && window_on && (oldest_before != '0) &&
                 ((stamp - oldest_before) < SW'(XAW));
    nxt_earliest = cur_earliest;
    if (act) begin
      if (spacing_at > nxt_earliest) begin
        nxt_earliest = spacing_at;
      end
      if (window_hit && (window_at > nxt_earliest)) begin
        nxt_earliest = window_at;
      end
    end
  end

endmodule

// File: rtl/bank_counter.sv
module bank_counter
  import rank_act_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count
);

  cnt_step_e     step;
  logic [CW-1:0] count_d;
  logic          count_en;

  always_comb begin
    step = CNT_HOLD;
    if (inc && !dec && count != CW'(BANKS)) begin
      step = CNT_UP;
    end else if (dec && !inc && count != '0) begin
      step = CNT_DOWN;
    end
    count_en = (step != CNT_HOLD);
    count_d  = (step == CNT_UP) ? count + CW'(1) : count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (count_en) begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/rank_act_limiter.sv
module rank_act_limiter #(
  parameter int STAMP_W = 16,
  parameter int MAX_X   = 8,
  parameter int RRD     = 4,
  parameter int XAW     = 20,
  parameter int BANKS   = 8,
  localparam int LW     = $clog2(MAX_X + 1),
  localparam int CW     = $clog2(BANKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_valid,
  input  logic [STAMP_W-1:0] act_stamp,
  input  logic [LW-1:0]      act_limit,
  input  logic               pre_valid,
  output logic [STAMP_W-1:0] earliest_act,
  output logic               violation,
  output logic [CW-1:0]      active_banks
);

  logic [LW-1:0]      depth_sel;
  logic [STAMP_W-1:0] oldest_before;
  logic [STAMP_W-1:0] oldest_after;
  logic [STAMP_W-1:0] earliest_d;
  logic               breach;
  logic               viol_q;

  assign depth_sel = (act_limit > LW'(MAX_X)) ? LW'(MAX_X) : act_limit;

  act_history #(.DEPTH(MAX_X), .SW(STAMP_W), .LW(LW)) u_hist (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (act_valid),
    .stamp         (act_stamp),
    .depth_sel     (depth_sel),
    .oldest_before (oldest_before),
    .oldest_after  (oldest_after)
  );

  act_window_calc #(.SW(STAMP_W), .RRD(RRD), .XAW(XAW)) u_calc (
    .act           (act_valid),
    .stamp         (act_stamp),
    .window_on     (depth_sel != '0),
    .oldest_before (oldest_before),
    .oldest_after  (oldest_after),
    .cur_earliest  (earliest_act),
    .nxt_earliest  (earliest_d),
    .breach        (breach)
  );

  bank_counter #(.BANKS(BANKS), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (act_valid),
    .dec   (pre_valid),
    .count (active_banks)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      earliest_act <= '0;
    end else if (act_valid) begin
      earliest_act <= earliest_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
    end else if (breach) begin
      viol_q <= 1'b1;
    end
  end

  assign violation = viol_q | breach;

endmodule

// File: rtl/rank_act_limiter_chk.sv
module rank_act_limiter_chk #(
  parameter int STAMP_W = 16,
  parameter int RRD     = 4,
  parameter int BANKS   = 8,
  parameter int LW      = 4,
  parameter int CW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               act_valid,
  input logic [STAMP_W-1:0] act_stamp,
  input logic [LW-1:0]      act_limit,
  input logic               pre_valid,
  input logic [STAMP_W-1:0] earliest_act,
  input logic               violation,
  input logic [CW-1:0]      active_banks
);

  p_never_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    earliest_act >= $past(earliest_act));

  p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> earliest_act >= ($past(act_stamp) + STAMP_W'(RRD)));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |=> $stable(earliest_act));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  p_cause_r4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> (act_valid && act_limit != '0));

  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active_banks <= CW'(BANKS));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && !act_valid && active_banks != '0)
      |=> active_banks == $past(active_banks) - CW'(1));

endmodule

bind rank_act_limiter rank_act_limiter_chk #(
  .STAMP_W(STAMP_W), .RRD(RRD), .BANKS(BANKS), .LW(LW), .CW(CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .act_valid    (act_valid),
  .act_stamp    (act_stamp),
  .act_limit    (act_limit),
  .pre_valid    (pre_valid),
  .earliest_act (earliest_act),
  .violation    (violation),
  .active_banks (active_banks)
);

// File: tb/rank_act_limiter_test.sv
module rank_act_limiter_test;

  localparam int SW    = 16;
  localparam int MAXX  = 8;
  localparam int RRD   = 4;
  localparam int XAW   = 20;
  localparam int BANKS = 8;
  localparam int LW    = $clog2(MAXX + 1);
  localparam int CW    = $clog2(BANKS + 1);

  logic          clk;
  logic          rst_n;
  logic          act_valid;
  logic [SW-1:0] act_stamp;
  logic [LW-1:0] act_limit;
  logic          pre_valid;
  logic [SW-1:0] earliest_act;
  logic          violation;
  logic [CW-1:0] active_banks;

  int n_cmp;
  int n_bad;

  int m_hist [MAXX];
  int m_early;
  int m_viol;
  int m_cnt;

  rank_act_limiter #(.STAMP_W(SW), .MAX_X(MAXX), .RRD(RRD), .XAW(XAW),
                     .BANKS(BANKS)) uut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_stamp(act_stamp),
    .act_limit(act_limit), .pre_valid(pre_valid), .earliest_act(earliest_act),
    .violation(violation), .active_banks(active_banks)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int eff_lim(input int lim);
    return (lim > MAXX) ? MAXX : lim;
  endfunction

  function automatic int m_breach(input int act, input int stamp, input int lim);
    int l;
    l = eff_lim(lim);
    if (act == 0 || l == 0) return 0;
    if (m_hist[l-1] == 0) return 0;
    return ((stamp - m_hist[l-1]) < XAW) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < MAXX; i++) m_hist[i] = 0;
    m_early = 0;
    m_viol  = 0;
    m_cnt   = 0;
  endtask

  task automatic model_step(input int act, input int stamp, input int lim, input int pre);
    int l;
    int o;
    l = eff_lim(lim);
    if (m_breach(act, stamp, lim) != 0) m_viol = 1;
    if (act != 0) begin
      for (int i = MAXX - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = stamp;
      if (stamp + RRD > m_early) m_early = stamp + RRD;
      if (l > 0) begin
        o = m_hist[l-1];
        if (o != 0 && (stamp - o) < XAW && o + XAW > m_early) m_early = o + XAW;
      end
    end
    if (act != 0 && pre == 0 && m_cnt < BANKS) m_cnt++;
    else if (pre != 0 && act == 0 && m_cnt > 0) m_cnt--;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    act_valid = 1'b0;
    pre_valid = 1'b0;
    act_stamp = '0;
    act_limit = '0;
    model_reset();
    @(negedge clk);
    check("R1", "earliest in reset", int'(earliest_act), 0);
    check("R1", "violation in reset", int'(violation), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "earliest after reset", int'(earliest_act), 0);
    check("R1", "count after reset", int'(active_banks), 0);
  endtask

  task automatic cyc(input string tag, input int act, input int stamp, input int lim, input int pre);
    @(negedge clk);
    act_valid = act[0];
    act_stamp = SW'(stamp);
    act_limit = LW'(lim);
    pre_valid = pre[0];
    #1;
    check(tag, "violation same cycle", int'(violation),
          (m_viol != 0 || m_breach(act, stamp, lim) != 0) ? 1 : 0);
    model_step(act, stamp, lim, pre);
    @(negedge clk);
    act_valid = 1'b0;
    pre_valid = 1'b0;
    #1;
    check(tag, "earliest", int'(earliest_act), m_early);
    check(tag, "violation", int'(violation), m_viol);
    check(tag, "bank count", int'(active_banks), m_cnt);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int stamp;
    int lim;
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    act_valid = 1'b0;
    pre_valid = 1'b0;
    act_stamp = '0;
    act_limit = '0;
    model_reset();
    do_reset();

    // R2 R6: first activate, empty history does not constrain
    cyc("R2 R6", 1, 10, 4, 0);
    check("R2", "earliest = 10+RRD", int'(earliest_act), 14);
    cyc("R6", 1, 12, 4, 0);
    cyc("R6", 1, 14, 4, 0);
    check("R6", "empty slot ignored", int'(earliest_act), 18);
    // R3: fourth activate fills window, limit = 10+XAW
    cyc("R3", 1, 16, 4, 0);
    check("R3", "window limit", int'(earliest_act), 30);
    // R4: fifth activate inside window
    cyc("R4", 1, 18, 4, 0);
    check("R4", "violation raised", int'(violation), 1);
    cyc("R4", 0, 0, 4, 0);
    cyc("R4", 0, 0, 4, 0);
    check("R4", "violation sticky", int'(violation), 1);

    // R5: limit zero, only spacing
    do_reset();
    for (int i = 0; i < 10; i++) cyc("R5", 1, 5 + i, 0, 0);
    check("R5", "only RRD", int'(earliest_act), 18);
    check("R5", "no violation", int'(violation), 0);

    // R7: limit above MAX_X clamps to MAX_X
    do_reset();
    for (int i = 1; i <= 8; i++) cyc("R7", 1, i, 15, 0);
    check("R7", "clamped window limit", int'(earliest_act), 21);
    check("R7", "no violation yet", int'(violation), 0);
    cyc("R7", 1, 9, 15, 0);
    check("R7", "violation at ninth", int'(violation), 1);

    // R8: counter saturation and simultaneous events
    do_reset();
    cyc("R8", 0, 0, 0, 1);
    check("R8", "no underflow", int'(active_banks), 0);
    for (int i = 0; i < 10; i++) cyc("R8", 1, 100 + 10 * i, 0, 0);
    check("R8", "saturate high", int'(active_banks), BANKS);
    cyc("R8", 1, 300, 0, 1);
    check("R8", "act+pre hold", int'(active_banks), BANKS);
    cyc("R8", 0, 0, 0, 1);
    check("R8", "decrement", int'(active_banks), BANKS - 1);

    // R2 R3 R4 R8: seeded random bursts
    do_reset();
    void'($urandom(32'h5eed_1234));
    stamp = 1;
    lim = 4;
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 40) == 0) lim = $urandom % 10;
      if (($urandom % 2) == 0) stamp = stamp + 1 + ($urandom % 3);
      else stamp = stamp + 1 + ($urandom % 12);
      cyc("R2 R3 R4 R8", ($urandom % 4) != 0 ? 1 : 0, stamp, lim, ($urandom % 3) == 0 ? 1 : 0);
      if (i == 300) do_reset();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule